// File: doc/BRIEF.md
# Frame Writeback Control and Status Sequencer

This block holds the single control and status word of a frame writeback engine and steps each frame through its life: start, run, optional abort with drain, and return to idle. Software talks to it through a small register port (address, write strobe, write data, combinational read data). The pixel datapath and the memory bus master sit outside and see only a one-cycle start strobe, a one-cycle abort strobe, a bus write permission level, and a frame-done input they raise when a frame has been fully committed.

Software arms a frame by writing the go bit. The block tracks busy in hardware and, if the interrupt enable bit is set when the frame ends (normally or after an abort), holds an interrupt line until software writes the enable bit back to zero. A re-arm bit makes the block emit a fresh frame-start event toward the upstream source each time a frame completes normally. A power-down bit is exported for the engine's internal memory, and the top ten bits read back as fixed identification values.

Top module: `wbcs_top`

## Requirements
- R1: After reset the control word at offset 0x0c reads 0x5440_0000, and the interrupt, start, abort, re-arm and bus write outputs are low.
- R2: Bits 31:24 always read 0x54 and bits 23:22 always read 0b01, whatever is written; bits 21 (power-down), 15 (re-arm) and 2 (interrupt enable) read back the last value written; all other bits, including go (bit 0) and abort (bit 14), read 0.
- R3: Writing bit 0 = 1 with bit 21 = 0 while idle produces a one-cycle start pulse in the cycle after the write, sets busy (bit 1) in that same cycle and raises bus write permission.
- R4: A frame-done input while running clears busy and bus write permission in the following cycle.
- R5: A go write while busy produces no start pulse and leaves busy set.
- R6: A go write whose bit 21 is 1 is ignored (no start pulse, busy stays 0); the power-down output follows bit 21 from the cycle after the write.
- R7: Writing bit 14 = 1 while running produces a one-cycle abort pulse and drops bus write permission in the cycle after the write; busy then clears exactly DRAIN_CYCLES clock edges after the write edge, or earlier if frame-done arrives during the drain.
- R8: Writing bit 14 = 1 while idle has no effect: no abort pulse, busy stays 0, the read value is unchanged.
- R9: If bit 2 is 1 when a frame ends, the interrupt output rises in the same cycle busy clears, is only ever high while idle, and stays high until a write sets bit 2 to 0.
- R10: A frame ended by abort raises the interrupt in the same way as a completed frame.
- R11: If bit 2 is 0 when a frame ends, no interrupt is raised.
- R12: With bit 15 = 1, a normal frame completion produces a one-cycle re-arm pulse in the cycle busy clears; no pulse with bit 15 = 0 or when the frame ends by abort.
- R13: Writes to any address other than 0x0c change nothing, and reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| frame_done_i | input | 1 | Datapath reports the current frame fully committed or drained |
| frame_start_o | output | 1 | One-cycle start strobe to the datapath |
| frame_abort_o | output | 1 | One-cycle abort strobe to the datapath |
| bus_write_en_o | output | 1 | Permission for the bus master to issue memory writes |
| rearm_start_o | output | 1 | One-cycle repeated frame-start event at normal end of frame |
| mem_pwrdn_o | output | 1 | Power-down request for the internal memory |
| irq_o | output | 1 | Level interrupt on idle |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one cycle of the next register write or frame-done: busy in the read word, bus write permission and the strobes all derive from it, so a missed transition leaves busy set after frame-done or lets a second start pulse through. A miscounted drain is exposed by sampling busy on the last drain cycle and the one after it. A wrong pending-interrupt flag appears as an interrupt while busy, one that drops before the acknowledge write, or one after a frame that ended with the enable clear.

// File: rtl/wbcs_pkg.sv
package wbcs_pkg;

    localparam int CTRL_W     = 32;
    localparam int BIT_GO     = 0;
    localparam int BIT_BUSY   = 1;
    localparam int BIT_IRQEN  = 2;
    localparam int BIT_ABORT  = 14;
    localparam int BIT_REARM  = 15;
    localparam int BIT_PWRDN  = 21;

    localparam logic [7:0] ID_PILOT = 8'h54;
    localparam logic [1:0] ID_REV   = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } frame_st_e;

    typedef struct packed {
        logic irq_en;
        logic rearm;
        logic pwrdn;
    } ctrl_cfg_t;

    typedef struct packed {
        logic go;
        logic abort;
        logic ack;
    } ctrl_cmd_t;

    function automatic logic [CTRL_W-1:0] pack_status(ctrl_cfg_t cfg, logic busy);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[31:24]    = ID_PILOT;
        w[23:22]    = ID_REV;
        w[BIT_PWRDN] = cfg.pwrdn;
        w[BIT_REARM] = cfg.rearm;
        w[BIT_IRQEN] = cfg.irq_en;
        w[BIT_BUSY]  = busy;
        return w;
    endfunction

endpackage

// File: rtl/wbcs_ctrl_regs.sv
module wbcs_ctrl_regs
    import wbcs_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h0c
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              busy_i,
    output ctrl_cfg_t         cfg_o,
    output ctrl_cmd_t         cmd_o,
    output logic [CTRL_W-1:0] rdata_o
);

    logic sel;
    logic hit;
    logic unused_bits;

    assign sel = (addr == CTRL_OFFSET);
    assign hit = wr && sel;
    assign unused_bits = ^{wdata[31:22], wdata[20:16], wdata[13:3], wdata[BIT_BUSY]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (hit) begin
            cfg_o.irq_en <= wdata[BIT_IRQEN];
            cfg_o.rearm  <= wdata[BIT_REARM];
            cfg_o.pwrdn  <= wdata[BIT_PWRDN];
        end
    end

    // a go that arrives together with a power-down request is dropped here
    always_comb begin
        cmd_o.go    = hit && wdata[BIT_GO] && !wdata[BIT_PWRDN];
        cmd_o.abort = hit && wdata[BIT_ABORT];
        cmd_o.ack   = hit && !wdata[BIT_IRQEN];
    end

    assign rdata_o = sel ? pack_status(cfg_o, busy_i) : '0;

    // R6: the stored power-down bit tracks the previous accepted write
    a_r6_pwrdn_follows: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cfg_o.pwrdn == $past(wdata[BIT_PWRDN])));

    // R13: a write elsewhere leaves the stored bits alone
    a_r13_other_addr: assert property (@(posedge clk) disable iff (rst)
        (wr && !sel) |=> $stable(cfg_o));

endmodule

// File: rtl/wbcs_frame_fsm.sv
module wbcs_frame_fsm
    import wbcs_pkg::*;
#(
    parameter int DRAIN_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic abort_i,
    input  logic frame_done_i,
    input  logic rearm_i,
    output logic busy_o,
    output logic accept_o,
    output logic finish_o,
    output logic start_o,
    output logic abort_o,
    output logic wen_o,
    output logic restart_o
);

    localparam int CNT_W = $clog2(DRAIN_CYCLES + 1);

    frame_st_e        st;
    logic [CNT_W-1:0] drain_cnt;
    logic [CNT_W-1:0] drain_age;

    assign busy_o   = (st != ST_IDLE);
    assign wen_o    = (st == ST_RUN);
    assign accept_o = (st == ST_IDLE) && go_i;
    assign finish_o = ((st == ST_RUN) && frame_done_i) ||
                      ((st == ST_DRAIN) && (frame_done_i || drain_cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            drain_cnt <= '0;
            start_o   <= 1'b0;
            abort_o   <= 1'b0;
            restart_o <= 1'b0;
        end else begin
            start_o   <= 1'b0;
            abort_o   <= 1'b0;
            restart_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go_i) begin
                        st      <= ST_RUN;
                        start_o <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (frame_done_i) begin
                        st        <= ST_IDLE;
                        restart_o <= rearm_i;
                    end else if (abort_i) begin
                        st        <= ST_DRAIN;
                        abort_o   <= 1'b1;
                        drain_cnt <= CNT_W'(DRAIN_CYCLES - 1);
                    end
                end
                ST_DRAIN: begin
                    if (frame_done_i || drain_cnt == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        drain_cnt <= drain_cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // checker-side age of the current drain, independent of drain_cnt
    always_ff @(posedge clk) begin
        if (rst) begin
            drain_age <= '0;
        end else if (st == ST_DRAIN) begin
            drain_age <= drain_age + 1'b1;
        end else begin
            drain_age <= '0;
        end
    end

    // R3: a start strobe is always seen together with busy
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (busy_o && wen_o));

    // R4: frame-done while running returns to idle next cycle
    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        (wen_o && frame_done_i) |=> !busy_o);

    // R5: no start strobe while a frame was already in progress
    a_r5_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_o && go_i) |=> !start_o);

    // R7: bus writes are blocked the moment abort is reported
    a_r7_abort_halts: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (busy_o && !wen_o));

    // R7: drain never outlives its bound
    a_r7_drain_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN) |-> (drain_age < CNT_W'(DRAIN_CYCLES)));

    // R12: re-arm pulse only after a frame that ended normally
    a_r12_rearm_after_run: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> ($past(wen_o) && !busy_o));

endmodule

// File: rtl/wbcs_irq.sv
module wbcs_irq (
    input  logic clk,
    input  logic rst,
    input  logic finish_i,
    input  logic accept_i,
    input  logic ack_i,
    input  logic irq_en_i,
    input  logic busy_i,
    output logic irq_o
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (ack_i || accept_i) begin
            pend <= 1'b0;
        end else if (finish_i && irq_en_i) begin
            pend <= 1'b1;
        end
    end

    assign irq_o = pend && irq_en_i;

    // R9: the interrupt only appears while the engine is idle
    a_r9_irq_idle: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !busy_i);

    // R9: it holds until acknowledged
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_i && !accept_i) |=> irq_o);

    // R11: a frame ending with the enable clear leaves it low
    a_r11_no_irq_disabled: assert property (@(posedge clk) disable iff (rst)
        (finish_i && !irq_en_i && !irq_o) |=> !irq_o);

endmodule

// File: rtl/wbcs_top.sv
module wbcs_top
    import wbcs_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DRAIN_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              frame_done_i,
    output logic              frame_start_o,
    output logic              frame_abort_o,
    output logic              bus_write_en_o,
    output logic              rearm_start_o,
    output logic              mem_pwrdn_o,
    output logic              irq_o
);

    ctrl_cfg_t cfg;
    ctrl_cmd_t cmd;
    logic      busy;
    logic      accept;
    logic      finish;

    wbcs_ctrl_regs #(
        .ADDR_W      (ADDR_W),
        .CTRL_OFFSET (ADDR_W'('h0c))
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .busy_i  (busy),
        .cfg_o   (cfg),
        .cmd_o   (cmd),
        .rdata_o (reg_rdata)
    );

    wbcs_frame_fsm #(
        .DRAIN_CYCLES (DRAIN_CYCLES)
    ) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .go_i         (cmd.go),
        .abort_i      (cmd.abort),
        .frame_done_i (frame_done_i),
        .rearm_i      (cfg.rearm),
        .busy_o       (busy),
        .accept_o     (accept),
        .finish_o     (finish),
        .start_o      (frame_start_o),
        .abort_o      (frame_abort_o),
        .wen_o        (bus_write_en_o),
        .restart_o    (rearm_start_o)
    );

    wbcs_irq irq_i (
        .clk      (clk),
        .rst      (rst),
        .finish_i (finish),
        .accept_i (accept),
        .ack_i    (cmd.ack),
        .irq_en_i (cfg.irq_en),
        .busy_i   (busy),
        .irq_o    (irq_o)
    );

    assign mem_pwrdn_o = cfg.pwrdn;

endmodule

// File: tb/wbcs_top_tb_top.sv
`timescale 1ns/1ps
module wbcs_top_tb_top;

    localparam int DRAIN = 8;
    localparam logic [7:0] CTRL = 8'h0c;

    // {write data, expected read-back}; none starts a frame
    localparam logic [63:0] VECS [0:6] = '{
        {32'h0000_0000, 32'h5440_0000},
        {32'hFFFF_BFFE, 32'h5460_8004},
        {32'h0020_0000, 32'h5460_0000},
        {32'h0000_8000, 32'h5440_8000},
        {32'h0000_0004, 32'h5440_0004},
        {32'h0020_0001, 32'h5460_0000},
        {32'h0000_0000, 32'h5440_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = CTRL;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_done_i = 1'b0;
    logic        frame_start_o, frame_abort_o, bus_write_en_o;
    logic        rearm_start_o, mem_pwrdn_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wbcs_top #(.ADDR_W(8), .DRAIN_CYCLES(DRAIN)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .frame_done_i   (frame_done_i),
        .frame_start_o  (frame_start_o),
        .frame_abort_o  (frame_abort_o),
        .bus_write_en_o (bus_write_en_o),
        .rearm_start_o  (rearm_start_o),
        .mem_pwrdn_o    (mem_pwrdn_o),
        .irq_o          (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = CTRL;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = CTRL;
        #0.5;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        frame_done_i = 1'b1;
        @(negedge clk);
        frame_done_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(CTRL, r);
        check("R1 read", r, 32'h5440_0000);
        check("R1 outputs", {26'd0, frame_start_o, frame_abort_o, bus_write_en_o,
              rearm_start_o, mem_pwrdn_o, irq_o}, 32'd0);

        // R2/R6: read-back table
        for (int i = 0; i < 7; i++) begin
            wr(CTRL, VECS[i][63:32]);
            rd(CTRL, r);
            check("R2 readback", r, VECS[i][31:0]);
            check("R6 pwrdn out", {31'd0, mem_pwrdn_o}, {31'd0, VECS[i][21]});
            check("R6 no start", {31'd0, frame_start_o}, 32'd0);
        end

        // R13: foreign address
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, r);
        check("R13 foreign read", r, 32'd0);
        rd(CTRL, r);
        check("R13 ctrl unchanged", r, 32'h5440_0000);
        check("R13 no start", {31'd0, frame_start_o}, 32'd0);

        // R3: start with interrupt enable
        wr(CTRL, 32'h0000_0005);
        check("R3 start pulse", {31'd0, frame_start_o}, 32'd1);
        check("R3 bus wen", {31'd0, bus_write_en_o}, 32'd1);
        rd(CTRL, r);
        check("R3 busy read", r, 32'h5440_0006);
        @(negedge clk);
        check("R3 pulse one cycle", {31'd0, frame_start_o}, 32'd0);

        // R5: go while busy
        wr(CTRL, 32'h0000_0005);
        check("R5 no start", {31'd0, frame_start_o}, 32'd0);
        rd(CTRL, r);
        check("R5 still busy", r, 32'h5440_0006);

        // R4/R9: completion
        pulse_done();
        check("R4 wen low", {31'd0, bus_write_en_o}, 32'd0);
        rd(CTRL, r);
        check("R4 idle", r, 32'h5440_0004);
        check("R9 irq rise", {31'd0, irq_o}, 32'd1);
        check("R12 no rearm", {31'd0, rearm_start_o}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 irq hold", {31'd0, irq_o}, 32'd1);
        wr(CTRL, 32'h0000_0000);
        check("R9 irq ack", {31'd0, irq_o}, 32'd0);

        // R11: enable clear at end of frame
        wr(CTRL, 32'h0000_0001);
        pulse_done();
        check("R11 no irq", {31'd0, irq_o}, 32'd0);

        // R12: re-arm pulse
        wr(CTRL, 32'h0000_8005);
        pulse_done();
        check("R12 rearm pulse", {31'd0, rearm_start_o}, 32'd1);
        @(negedge clk);
        check("R12 rearm one cycle", {31'd0, rearm_start_o}, 32'd0);
        wr(CTRL, 32'h0000_8000);

        // R7/R10: abort with full drain
        wr(CTRL, 32'h0000_8005);
        wr(CTRL, 32'h0000_C004);
        check("R7 abort pulse", {31'd0, frame_abort_o}, 32'd1);
        check("R7 wen dropped", {31'd0, bus_write_en_o}, 32'd0);
        repeat (DRAIN - 1) @(negedge clk);
        rd(CTRL, r);
        check("R7 busy last drain", {31'd0, r[1]}, 32'd1);
        check("R12 no rearm abort", {31'd0, rearm_start_o}, 32'd0);
        @(negedge clk);
        rd(CTRL, r);
        check("R7 idle after drain", {31'd0, r[1]}, 32'd0);
        check("R10 irq after abort", {31'd0, irq_o}, 32'd1);
        check("R12 no rearm abort end", {31'd0, rearm_start_o}, 32'd0);
        wr(CTRL, 32'h0000_0000);

        // R7: early end of drain
        wr(CTRL, 32'h0000_0001);
        wr(CTRL, 32'h0000_4000);
        pulse_done();
        rd(CTRL, r);
        check("R7 early drain end", {31'd0, r[1]}, 32'd0);

        // R8: abort while idle
        wr(CTRL, 32'h0000_4000);
        check("R8 no abort pulse", {31'd0, frame_abort_o}, 32'd0);
        rd(CTRL, r);
        check("R8 read unchanged", r, 32'h5440_0000);

        // R6: go with power-down
        wr(CTRL, 32'h0020_0001);
        check("R6 start ignored", {31'd0, frame_start_o}, 32'd0);
        check("R6 pwrdn high", {31'd0, mem_pwrdn_o}, 32'd1);
        rd(CTRL, r);
        check("R6 not busy", {31'd0, r[1]}, 32'd0);
        wr(CTRL, 32'h0000_0000);
        check("R6 pwrdn low", {31'd0, mem_pwrdn_o}, 32'd0);

        finish_run();
    end

endmodule